// File: doc/BRIEF.md
# Motor Drive Output Formatter

This block sits between a motor control loop and the motor drive electronics. It accepts a signed 12-bit torque demand and presents it in one of three selectable formats: a held 8-bit offset-binary byte for a converter without an input latch, a 12-bit offset-binary word sent as two 6-bit halves with a strobe for each half so an external latch can rebuild it, or a sign line plus a pulse-width-modulated magnitude line for a switch-mode amplifier.

Time is divided into sample periods of 256 clocks. The first period begins on the first rising edge after reset is released. The demand and the format select are captured only on the first edge of a period. As a result, no output changes partway through a multiplexed pair or a pulse period. Outputs of the formats that are not selected rest at fixed idle values.

Top module: `motor_out_fmt`

## Requirements
- R1: While `rstN` is low, `par8Out` is 0x80, `muxOut` is 0, and `strobeHi`, `strobeLo`, `pwmSign` and `pwmMag` are all 0.
- R2: A sample period is 256 clocks long and starts on the first rising edge after reset release. `demand` and `modeSel` are captured only on that edge. Changing them at any other time has no effect on any output until the next period starts.
- R3: With `modeSel` = 2'b00, `par8Out` takes the value (demand >>> 4) + 0x80 on the period's first edge. So -2048 gives 0x00, 0 gives 0x80 and 2047 gives 0xFF. The value is held for the whole period.
- R4: With `modeSel` = 2'b01, let code = demand + 0x800, a 12-bit value. On the period's first edge, `muxOut` takes code[11:6] and `strobeHi` goes high for exactly one clock.
- R5: In the same mode, on the third edge of the period (phase 2), `muxOut` takes code[5:0] and `strobeLo` goes high for exactly one clock. `muxOut` keeps the low half until the next period.
- R6: With `modeSel` = 2'b10, `pwmSign` becomes 1 on the period's first edge when the demand is negative and 0 otherwise. It is held for the whole period.
- R7: In the same mode, the magnitude is min(|demand| >> 3, 255). After the edge at phase k (k = 0..255), `pwmMag` is 1 exactly when k < magnitude. A magnitude of 0 keeps `pwmMag` low for the whole period.
- R8: Outputs of unselected formats stay idle: `par8Out` = 0x80 when not in byte mode, `muxOut` = 0 and both strobes 0 when not in split mode, and `pwmSign` = `pwmMag` = 0 when not in pulse mode.
- R9: `modeSel` = 2'b11 behaves exactly like 2'b00 (byte mode).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| demand | input | 12 | Signed torque demand, two's complement |
| modeSel | input | 2 | Format select: 00 byte, 01 split 12-bit, 10 pulse, 11 byte |
| par8Out | output | 8 | Held offset-binary byte |
| muxOut | output | 6 | Current half of the split 12-bit offset-binary word |
| strobeHi | output | 1 | One-clock marker that the high half is on `muxOut` |
| strobeLo | output | 1 | One-clock marker that the low half is on `muxOut` |
| pwmSign | output | 1 | Sign of the demand in pulse mode, 1 = negative |
| pwmMag | output | 1 | Pulse train whose high time is the magnitude out of 256 clocks |

## Verification
The bench drives the full-scale ends of the range:
- -2048 must give byte 0x00 and a pulse magnitude of 255. A design that took the absolute value without saturating would wrap this case to magnitude 0.
- -1 must give byte 0x7F and a negative sign with zero magnitude. A design that rounded toward zero would produce 0x80 here.

For the split word, the bench checks both halves, the order and position of the strobes, and that each strobe lasts exactly one clock. A strobe that is late or too wide would either latch the wrong half or latch the right half twice.

In every period the bench changes the demand and the format select partway through. A design that sampled them outside the period start would show a changed output or a torn pulse.

The bench also switches between formats, so that outputs left at a stale value instead of returning to idle are caught.

// File: rtl/mof_pkg.sv
package mof_pkg;

  typedef enum logic [1:0] {
    MODE_PAR8  = 2'b00,
    MODE_MUX12 = 2'b01,
    MODE_PWM   = 2'b10,
    MODE_RSVD  = 2'b11
  } outMode_e;

  // Strobes from sequencing control to the datapath
  typedef struct packed {
    logic load;    // first edge of a sample period
    logic emitLo;  // slot for the low half of the split word
  } seqStrobe_t;

endpackage

// File: rtl/mof_ctrl.sv
module mof_ctrl
  import mof_pkg::*;
#(
  parameter int PHASE_W = 8,
  parameter int LO_SLOT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  output seqStrobe_t         strobes,
  output logic [PHASE_W-1:0] phase
);

  localparam logic [PHASE_W-1:0] LO_AT = PHASE_W'(LO_SLOT);

  always_ff @(posedge clk) begin
    if (!rstN) phase <= '0;
    else       phase <= phase + 1'b1;
  end

  always_comb begin
    strobes.load   = (phase == '0);
    strobes.emitLo = (phase == LO_AT);
  end

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> phase == $past(phase) + 1'b1);

endmodule

// File: rtl/mof_datapath.sv
module mof_datapath
  import mof_pkg::*;
#(
  parameter int DEMAND_W = 12,
  parameter int PAR_W    = 8,
  parameter int PWM_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          st,
  input  logic [PWM_BITS-1:0] phase,
  input  logic [DEMAND_W-1:0] demand,
  input  logic [1:0]          modeSel,
  output logic [PAR_W-1:0]    par8Out,
  output logic [DEMAND_W/2-1:0] muxOut,
  output logic                strobeHi,
  output logic                strobeLo,
  output logic                pwmSign,
  output logic                pwmMag
);

  localparam int HALF_W    = DEMAND_W / 2;
  localparam int MAG_SHIFT = DEMAND_W - 1 - PWM_BITS;
  localparam logic [PAR_W-1:0]    PAR_ZERO = {1'b1, {(PAR_W-1){1'b0}}};
  localparam logic [DEMAND_W-1:0] MAG_CAP  = DEMAND_W'((1 << PWM_BITS) - 1);

  outMode_e            modeReg, modeEff, modeNow;
  logic [PWM_BITS-1:0] magReg, magNew, magNow;
  logic [HALF_W-1:0]   lowHalf;
  logic [DEMAND_W-1:0] code12, absVal, scaled;
  logic [PAR_W-1:0]    parCode;

  // Offset binary: flipping the sign bit adds half of full scale
  always_comb begin
    code12 = {~demand[DEMAND_W-1], demand[DEMAND_W-2:0]};
  end

  generate
    if (PAR_W == DEMAND_W) begin : g_parFull
      always_comb parCode = code12;
    end else begin : g_parTrunc
      always_comb parCode = code12[DEMAND_W-1 -: PAR_W];
    end
  endgenerate

  // Magnitude: absolute value scaled to the pulse range, with saturation
  always_comb begin
    absVal = demand[DEMAND_W-1] ? (~demand + 1'b1) : demand;
    scaled = absVal >> MAG_SHIFT;
    magNew = (scaled > MAG_CAP) ? MAG_CAP[PWM_BITS-1:0] : scaled[PWM_BITS-1:0];
  end

  always_comb begin
    modeEff = (outMode_e'(modeSel) == MODE_RSVD) ? MODE_PAR8 : outMode_e'(modeSel);
    modeNow = st.load ? modeEff : modeReg;
    magNow  = st.load ? magNew  : magReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg  <= MODE_PAR8;
      magReg   <= '0;
      lowHalf  <= '0;
      par8Out  <= PAR_ZERO;
      muxOut   <= '0;
      strobeHi <= 1'b0;
      strobeLo <= 1'b0;
      pwmSign  <= 1'b0;
      pwmMag   <= 1'b0;
    end else begin
      if (st.load) begin
        modeReg  <= modeEff;
        magReg   <= magNew;
        lowHalf  <= code12[HALF_W-1:0];
        par8Out  <= (modeEff == MODE_PAR8) ? parCode : PAR_ZERO;
        pwmSign  <= (modeEff == MODE_PWM) && demand[DEMAND_W-1];
        muxOut   <= (modeEff == MODE_MUX12) ? code12[DEMAND_W-1 -: HALF_W] : '0;
        strobeHi <= (modeEff == MODE_MUX12);
      end else begin
        strobeHi <= 1'b0;
      end
      if (st.emitLo && modeReg == MODE_MUX12) muxOut <= lowHalf;
      strobeLo <= st.emitLo && (modeReg == MODE_MUX12);
      pwmMag   <= (modeNow == MODE_PWM) && (phase < magNow);
    end
  end

  // R4
  strobe_hi_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeHi |=> !strobeHi);

  // R5
  strobe_lo_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobeLo |-> $past(strobeHi, 2) && !strobeHi);

  // R2
  hold_midperiod_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != '0) |=> $stable(par8Out) && $stable(pwmSign));

  // R7
  pwm_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && magReg == '0) |=> !pwmMag);

  // R8
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg != MODE_PWM) |-> !pwmMag && !pwmSign);

  // R8
  mux_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg != MODE_MUX12) |-> muxOut == '0 && !strobeHi && !strobeLo);

endmodule

// File: rtl/motor_out_fmt.sv
module motor_out_fmt
  import mof_pkg::*;
#(
  parameter int DEMAND_W = 12,
  parameter int PAR_W    = 8,
  parameter int PWM_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DEMAND_W-1:0]   demand,
  input  logic [1:0]            modeSel,
  output logic [PAR_W-1:0]      par8Out,
  output logic [DEMAND_W/2-1:0] muxOut,
  output logic                  strobeHi,
  output logic                  strobeLo,
  output logic                  pwmSign,
  output logic                  pwmMag
);

  seqStrobe_t          seqStrobes;
  logic [PWM_BITS-1:0] phase;

  mof_ctrl #(.PHASE_W(PWM_BITS), .LO_SLOT(2)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (seqStrobes),
    .phase   (phase)
  );

  mof_datapath #(.DEMAND_W(DEMAND_W), .PAR_W(PAR_W), .PWM_BITS(PWM_BITS)) uData (
    .clk      (clk),
    .rstN     (rstN),
    .st       (seqStrobes),
    .phase    (phase),
    .demand   (demand),
    .modeSel  (modeSel),
    .par8Out  (par8Out),
    .muxOut   (muxOut),
    .strobeHi (strobeHi),
    .strobeLo (strobeLo),
    .pwmSign  (pwmSign),
    .pwmMag   (pwmMag)
  );

endmodule

// File: tb/sim_motor_out_fmt.sv
module sim_motor_out_fmt;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] demand = '0;
  logic [1:0]  modeSel = '0;
  logic [7:0]  par8Out;
  logic [5:0]  muxOut;
  logic        strobeHi, strobeLo, pwmSign, pwmMag;

  int nChecks = 0;
  int nFails  = 0;
  int bp      = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  // Period position from the requirement: 256 clocks from first edge after reset
  always @(posedge clk) begin
    if (!rstN) bp <= 0;
    else       bp <= (bp + 1) % 256;
  end

  motor_out_fmt u0 (
    .clk(clk), .rstN(rstN), .demand(demand), .modeSel(modeSel),
    .par8Out(par8Out), .muxOut(muxOut), .strobeHi(strobeHi), .strobeLo(strobeLo),
    .pwmSign(pwmSign), .pwmMag(pwmMag)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // R1
  task automatic checkReset();
    @(negedge clk);
    check(par8Out == 8'h80, "R1 par8Out in reset", par8Out, 128);
    check(muxOut == 6'd0, "R1 muxOut in reset", muxOut, 0);
    check({strobeHi, strobeLo, pwmSign, pwmMag} == 4'b0, "R1 control lines in reset",
          {strobeHi, strobeLo, pwmSign, pwmMag}, 0);
  endtask

  // One full sample period with a mid-period disturbance (R2)
  task automatic runFrame(input logic [1:0] m, input int dem, input string tag);
    int effM, e8, e12, hi, lo, absd, mg, highCnt;
    int bad[6], fa[6], fe[6];
    int midBad;
    string parReq;
    effM = (m == 2'b11) ? 0 : int'(m);
    e8   = ((dem >>> 4) + 128) & 255;
    e12  = dem + 2048;
    hi   = e12 >> 6;
    lo   = e12 & 63;
    absd = (dem < 0) ? -dem : dem;
    mg   = absd >> 3;
    if (mg > 255) mg = 255;
    highCnt = 0;
    midBad  = 0;
    for (int i = 0; i < 6; i++) begin bad[i] = 0; fa[i] = 0; fe[i] = 0; end
    parReq = (m == 2'b11) ? "R9" : ((effM == 0) ? "R3" : "R8");

    while (bp != 0) @(negedge clk);
    modeSel = m;
    demand  = 12'(dem);
    for (int k = 0; k < 256; k++) begin
      int ex[6], ac[6];
      @(negedge clk);
      if (k == 100) begin
        demand  = ~12'(dem);
        modeSel = m ^ 2'b01;
      end
      ex[0] = (effM == 0) ? e8 : 128;
      ex[1] = (effM == 1) ? ((k < 2) ? hi : lo) : 0;
      ex[2] = (effM == 1 && k == 0) ? 1 : 0;
      ex[3] = (effM == 1 && k == 2) ? 1 : 0;
      ex[4] = (effM == 2 && dem < 0) ? 1 : 0;
      ex[5] = (effM == 2 && k < mg) ? 1 : 0;
      ac[0] = par8Out; ac[1] = muxOut; ac[2] = strobeHi;
      ac[3] = strobeLo; ac[4] = pwmSign; ac[5] = pwmMag;
      for (int i = 0; i < 6; i++) begin
        if (ac[i] != ex[i]) begin
          if (bad[i] == 0) begin fa[i] = ac[i]; fe[i] = ex[i]; end
          bad[i]++;
          if (k >= 100) midBad++;
        end
      end
      if (pwmMag) highCnt++;
    end
    check(bad[0] == 0, {parReq, " par8Out ", tag}, fa[0], fe[0]);
    check(bad[1] == 0, {(effM == 1) ? "R4/R5" : "R8", " muxOut ", tag}, fa[1], fe[1]);
    check(bad[2] == 0, {(effM == 1) ? "R4" : "R8", " strobeHi ", tag}, fa[2], fe[2]);
    check(bad[3] == 0, {(effM == 1) ? "R5" : "R8", " strobeLo ", tag}, fa[3], fe[3]);
    check(bad[4] == 0, {(effM == 2) ? "R6" : "R8", " pwmSign ", tag}, fa[4], fe[4]);
    check(bad[5] == 0, {(effM == 2) ? "R7" : "R8", " pwmMag pattern ", tag}, fa[5], fe[5]);
    check(highCnt == ((effM == 2) ? mg : 0), {"R7 pwm high time ", tag},
          highCnt, (effM == 2) ? mg : 0);
    check(midBad == 0, {"R2 mid-period change ignored ", tag}, midBad, 0);
  endtask

  initial begin : main
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    checkReset();
    @(negedge clk);
    rstN = 1'b1;

    // R3 byte mode
    runFrame(2'b00, 0, "par zero");
    runFrame(2'b00, -2048, "par min");
    runFrame(2'b00, 2047, "par max");
    runFrame(2'b00, -1, "par minus one");
    runFrame(2'b00, 291, "par mid");
    // R9 reserved select
    runFrame(2'b11, -300, "reserved select");
    // R4 R5 split word
    runFrame(2'b01, 1443, "mux pattern");
    runFrame(2'b01, -1, "mux minus one");
    runFrame(2'b01, -2048, "mux min");
    // R6 R7 pulse mode
    runFrame(2'b10, 0, "pwm zero");
    runFrame(2'b10, 40, "pwm small");
    runFrame(2'b10, -2048, "pwm saturate");
    runFrame(2'b10, 2047, "pwm max");
    runFrame(2'b10, -8, "pwm one");
    runFrame(2'b10, 7, "pwm below step");
    runFrame(2'b10, -100, "pwm negative");
    // R8 return to byte mode leaves pulse outputs idle
    runFrame(2'b00, 1000, "back to par");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule